// File: doc/BRIEF.md
# Single/Dual Address DMA Channel

This block is one DMA channel that moves data between external memory and an external peripheral over a shared bus. It has two modes. In two-cycle mode every transfer is a read bus cycle at the source pointer, followed by a write bus cycle at the destination pointer. The word read is held in an internal buffer between the two cycles. In one-cycle mode the peripheral is selected by an active-low acknowledge strobe instead of an address. Memory is addressed at the same time, so one transfer takes a single bus cycle.

Software writes a source pointer, a destination pointer, a transfer count and a control word through a write-only configuration port. A two-cycle channel starts as soon as it is armed with a non-zero count and runs until the count is used up. A one-cycle channel makes one transfer for each request pulse. After the last transfer the channel disarms itself. It can also mark that last transfer with a one-cycle end pulse.

Top module: `dma_chan`

## Requirements
- R1: In two-cycle mode (control bit 1 = 0), each transfer drives `bus_rd` with `bus_addr` = source pointer for one cycle. In the next cycle it drives `bus_wr` with `bus_addr` = destination pointer, and `bus_wdata` equals the `bus_rdata` sampled in the read cycle.
- R2: In one-cycle mode (control bit 1 = 1) with direction bit 2 = 0, a transfer is one cycle with `dack_n` = 0, `bus_rd` = 1, `bus_wr` = 0 and `bus_addr` = source pointer.
- R3: In one-cycle mode with direction bit 2 = 1, a transfer is one cycle with `dack_n` = 0, `bus_wr` = 1, `bus_rd` = 0 and `bus_addr` = destination pointer.
- R4: In one-cycle mode, the pointer not selected by the direction bit never changes, even when its increment bit is set.
- R5: `dack_n` is low only during a one-cycle-mode transfer, and needs no enable of its own. `bus_rd` and `bus_wr` are never high together, and both are low when no transfer is in progress.
- R6: `xfer_end` is high for exactly the bus cycle that completes the final transfer, and only when control bit 3 is set. It is never high otherwise.
- R7: The count drops by one per completed transfer. After the transfer that takes it from 1 to 0, the run bit (control bit 0) clears and no further transfers happen.
- R8: Control bit 4 makes the source pointer advance by STEP after each transfer that uses it, and control bit 5 does the same for the destination pointer. A cleared bit keeps that pointer fixed.
- R9: In one-cycle mode, a `dreq` high sampled at a rising edge while the channel is idle and armed starts exactly one transfer, in the following cycle. In two-cycle mode, the first read cycle follows the cycle in which the channel became armed with a non-zero count.
- R10: Configuration writes (`cfg_sel` 0 = source, 1 = destination, 2 = count, 3 = control) are ignored while a transfer is in progress. A channel armed with a count of zero stays idle.
- R11: After reset, all strobes are inactive and both pointers, the count and the control word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | AW | Configuration write data |
| dreq | input | 1 | Transfer request for one-cycle mode |
| bus_rdata | input | DW | Read data from the bus |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_wdata | output | DW | Write data in two-cycle mode |
| dack_n | output | 1 | Peripheral acknowledge, active low |
| xfer_end | output | 1 | End-of-transfer pulse |

## Verification
The assertions assume that `bus_rdata` is a defined value whenever `bus_rd` is high. They also assume that `dreq` changes only away from the rising clock edge. The stimulus derives the read data from the address and drives `dreq` as single-cycle pulses. It never writes the configuration in the cycle where an armed two-cycle channel is about to leave idle, so every start is caused either by a request or by a write that the bench itself tracks. Writes that arrive while the channel is busy are aimed at transfer cycles on purpose, so that the rule that drops them is exercised.

// File: rtl/dma_chan_pkg.sv
// Shared types for the DMA channel: sequencer states, register selects
// and the packed control word. Assumes a single channel per instance.
package dma_chan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_ONE  = 2'd3
    } dma_state_e;

    typedef enum logic [1:0] {
        SEL_SRC  = 2'd0,
        SEL_DST  = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    // Bit 0 is the least significant field (the last one listed).
    typedef struct packed {
        logic dst_inc;    // bit 5
        logic src_inc;    // bit 4
        logic eot_en;     // bit 3
        logic to_mem;     // bit 2: 1 = peripheral to memory
        logic one_cycle;  // bit 1: 1 = acknowledge-strobe mode
        logic run;        // bit 0
    } chan_ctrl_t;

    localparam int CTRL_W = $bits(chan_ctrl_t);

endpackage

// File: rtl/dma_chan_regs.sv
// Configuration registers of the channel: source and destination pointers,
// transfer count and control word. Software writes are dropped while the
// sequencer is busy. Hardware updates the pointers and the count at the end
// of each transfer, and clears the run bit after the final one.
// Assumes CW <= AW and CTRL_W <= AW.
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int AW   = 16,
    parameter int CW   = 16,
    parameter int STEP = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          busy,
    input  logic          xfer_done,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic [CW-1:0] cnt_q,
    output chan_ctrl_t    ctrl_q,
    output logic          last
);

    localparam logic [AW-1:0] STEP_V = AW'(STEP);
    localparam logic [CW-1:0] ONE_C  = CW'(1);

    logic use_src;
    logic use_dst;

    // Which pointers the current mode actually puts on the bus.
    always_comb begin
        use_src = !ctrl_q.one_cycle || !ctrl_q.to_mem;
        use_dst = !ctrl_q.one_cycle ||  ctrl_q.to_mem;
    end

    assign last = (cnt_q == ONE_C);

    // Register update: reset, hardware progress, or an accepted software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            ctrl_q <= '0;
        end else if (xfer_done) begin
            cnt_q <= cnt_q - ONE_C;
            if (last)
                ctrl_q.run <= 1'b0;
            if (ctrl_q.src_inc && use_src)
                src_q <= src_q + STEP_V;
            if (ctrl_q.dst_inc && use_dst)
                dst_q <= dst_q + STEP_V;
        end else if (cfg_we && !busy) begin
            case (reg_sel_e'(cfg_sel))
                SEL_SRC:  src_q  <= cfg_wdata;
                SEL_DST:  dst_q  <= cfg_wdata;
                SEL_CNT:  cnt_q  <= cfg_wdata[CW-1:0];
                default:  ctrl_q <= chan_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            endcase
        end
    end

    // R7: each completed transfer takes exactly one off the count.
    p_cnt_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> cnt_q == $past(cnt_q) - ONE_C);

    // R7: the final transfer disarms the channel.
    p_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && last) |=> !ctrl_q.run);

    // R10: nothing moves while a read cycle of a transfer is in flight.
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !xfer_done) |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q)));

    // R4: in memory-to-peripheral one-cycle mode the destination is left alone.
    p_unused_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && ctrl_q.one_cycle && !ctrl_q.to_mem) |=> $stable(dst_q));

    // R4: in peripheral-to-memory one-cycle mode the source is left alone.
    p_unused_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && ctrl_q.one_cycle && ctrl_q.to_mem) |=> $stable(src_q));

endmodule

// File: rtl/dma_chan_seq.sv
// Bus sequencer of the channel. Each clock is one bus cycle. Two-cycle mode
// runs read/write pairs back to back until the count is used up. One-cycle
// mode makes one acknowledge-strobed cycle per request. Strobes and the
// address decode straight from the state register.
// Assumes the register block holds its values steady while busy is high.
module dma_chan_seq
    import dma_chan_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  chan_ctrl_t    ctrl,
    input  logic [AW-1:0] src_q,
    input  logic [AW-1:0] dst_q,
    input  logic [CW-1:0] cnt_q,
    input  logic          last,
    input  logic          req,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] addr,
    output logic          rd,
    output logic          wr,
    output logic          ack_n,
    output logic          eot,
    output logic [DW-1:0] wdata,
    output logic          busy,
    output logic          xfer_done
);

    dma_state_e    state_q;
    dma_state_e    state_d;
    logic [DW-1:0] buf_q;
    logic          can_go;

    assign can_go = ctrl.run && (cnt_q != '0);

    // Next bus cycle selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (can_go) begin
                    if (!ctrl.one_cycle)
                        state_d = ST_RD;
                    else if (req)
                        state_d = ST_ONE;
                end
            end
            ST_RD:   state_d = ST_WR;
            ST_WR:   state_d = last ? ST_IDLE : ST_RD;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Hold the word fetched in the read cycle for the write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            buf_q <= '0;
        else if (state_q == ST_RD)
            buf_q <= rdata;
    end

    // Bus strobe, address and data decode for the current cycle.
    always_comb begin
        rd    = 1'b0;
        wr    = 1'b0;
        ack_n = 1'b1;
        addr  = '0;
        wdata = '0;
        case (state_q)
            ST_RD: begin
                rd   = 1'b1;
                addr = src_q;
            end
            ST_WR: begin
                wr    = 1'b1;
                addr  = dst_q;
                wdata = buf_q;
            end
            ST_ONE: begin
                ack_n = 1'b0;
                rd    = !ctrl.to_mem;
                wr    =  ctrl.to_mem;
                addr  = ctrl.to_mem ? dst_q : src_q;
            end
            default: ;
        endcase
    end

    assign busy      = (state_q != ST_IDLE);
    assign xfer_done = (state_q == ST_WR) || (state_q == ST_ONE);
    assign eot       = xfer_done && last && ctrl.eot_en;

    // R1: a two-cycle read is followed by a write carrying the word read.
    p_rd_then_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && ack_n) |=> (wr && wdata == $past(rdata)));

    // R2: the acknowledge strobe lasts a single cycle per request.
    p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |=> ack_n);

    // R3: an acknowledged cycle carries exactly one memory strobe.
    p_ack_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> (rd != wr));

    // R5: never read and write in the same cycle.
    p_no_rd_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd && wr));

    // R6: the end pulse only marks an enabled, real bus cycle.
    p_eot_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eot |-> (ctrl.eot_en && (rd || wr)));

    // R9: an accepted request yields an acknowledged cycle next.
    p_req_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && can_go && ctrl.one_cycle && req) |=> !ack_n);

endmodule

// File: rtl/dma_chan.sv
// Top of the single/dual address DMA channel. It joins the configuration
// registers to the bus sequencer. Each clock is one external bus cycle.
// Assumes bus_rdata is valid in the cycle where bus_rd is high.
module dma_chan
    import dma_chan_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int STEP = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          dreq,
    input  logic [DW-1:0] bus_rdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] bus_wdata,
    output logic          dack_n,
    output logic          xfer_end
);

    logic [AW-1:0] src_q;
    logic [AW-1:0] dst_q;
    logic [CW-1:0] cnt_q;
    chan_ctrl_t    ctrl_q;
    logic          last;
    logic          busy;
    logic          xfer_done;

    dma_chan_regs #(.AW(AW), .CW(CW), .STEP(STEP)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .busy      (busy),
        .xfer_done (xfer_done),
        .src_q     (src_q),
        .dst_q     (dst_q),
        .cnt_q     (cnt_q),
        .ctrl_q    (ctrl_q),
        .last      (last)
    );

    dma_chan_seq #(.AW(AW), .DW(DW), .CW(CW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl_q),
        .src_q     (src_q),
        .dst_q     (dst_q),
        .cnt_q     (cnt_q),
        .last      (last),
        .req       (dreq),
        .rdata     (bus_rdata),
        .addr      (bus_addr),
        .rd        (bus_rd),
        .wr        (bus_wr),
        .ack_n     (dack_n),
        .eot       (xfer_end),
        .wdata     (bus_wdata),
        .busy      (busy),
        .xfer_done (xfer_done)
    );

    // R5: the acknowledge strobe only appears in one-cycle mode.
    p_ack_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !dack_n |-> ctrl_q.one_cycle);

endmodule

// File: tb/sim_dma_chan.sv
`timescale 1ns/1ps
// Bench for dma_chan. A behavioural model predicts every bus cycle and
// pushes it into a queue. A negedge monitor pops one entry per clock,
// or expects an idle bus when the queue is empty.
module sim_dma_chan;

    localparam logic [15:0] KEY  = 16'h5A3C;
    localparam int          STEP = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        dreq = 1'b0;
    logic [15:0] bus_rdata;
    logic [15:0] bus_addr;
    logic        bus_rd;
    logic        bus_wr;
    logic [15:0] bus_wdata;
    logic        dack_n;
    logic        xfer_end;

    always #2 clk = ~clk;

    assign bus_rdata = bus_addr ^ KEY;

    dma_chan #(.AW(16), .DW(16), .CW(16), .STEP(STEP)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dreq(dreq), .bus_rdata(bus_rdata),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .dack_n(dack_n), .xfer_end(xfer_end)
    );

    typedef struct {
        logic [15:0] addr;
        logic [15:0] wd;
        bit rd, wr, ackn, eotv, xfer, cw;
        string tag;
    } ent_t;

    ent_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    bit   mon_on = 1'b0;
    bit   cur_busy = 1'b0;
    int   cyc = 0;

    // behavioural model state
    logic [15:0] m_src = '0, m_dst = '0, m_cnt = '0;
    bit m_run = 0, m_one = 0, m_tomem = 0, m_eoten = 0, m_si = 0, m_di = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic put(input logic [15:0] a, input bit r, input bit w, input bit an,
                       input bit e, input bit x, input bit c, input logic [15:0] d,
                       input string tag);
        ent_t n;
        n.addr = a; n.rd = r; n.wr = w; n.ackn = an; n.eotv = e;
        n.xfer = x; n.cw = c; n.wd = d; n.tag = tag;
        exp_q.push_back(n);
    endtask

    // Predicts a whole two-cycle run from the current model state.
    task automatic run_dual(input string tag);
        while (m_cnt != 0) begin
            put(m_src, 1, 0, 1, 0, 1, 0, '0, tag);
            put(m_dst, 0, 1, 1, m_eoten && (m_cnt == 1), 1, 1, m_src ^ KEY, tag);
            if (m_si) m_src = m_src + STEP;
            if (m_di) m_dst = m_dst + STEP;
            m_cnt = m_cnt - 1;
        end
        m_run = 0;
    endtask

    // Predicts one acknowledge-strobed transfer.
    task automatic one_xfer(input string tag);
        put(m_tomem ? m_dst : m_src, !m_tomem, m_tomem, 0,
            m_eoten && (m_cnt == 1), 1, 0, '0, tag);
        if (m_tomem && m_di) m_dst = m_dst + STEP;
        if (!m_tomem && m_si) m_src = m_src + STEP;
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) m_run = 0;
    endtask

    task automatic wreg(input logic [1:0] sel, input logic [15:0] val, input string tag);
        @(negedge clk); #1;
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        if (!cur_busy) begin
            case (sel)
                2'd0: m_src = val;
                2'd1: m_dst = val;
                2'd2: m_cnt = val;
                default: begin
                    m_run = val[0]; m_one = val[1]; m_tomem = val[2];
                    m_eoten = val[3]; m_si = val[4]; m_di = val[5];
                end
            endcase
            if (m_run && !m_one && m_cnt != 0) begin
                put('0, 0, 0, 1, 0, 0, 0, '0, tag);
                run_dual(tag);
            end
        end
        @(negedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic pulse_req(input string tag);
        @(negedge clk); #1;
        dreq = 1'b1;
        if (!cur_busy && m_run && m_one && m_cnt != 0)
            one_xfer(tag);
        @(negedge clk); #1;
        dreq = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Compares every cycle with the predicted bus cycle.
    always @(negedge clk) begin
        if (mon_on) begin
            ent_t e;
            if (exp_q.size() != 0) e = exp_q.pop_front();
            else begin
                e.addr = '0; e.wd = '0; e.rd = 0; e.wr = 0; e.ackn = 1;
                e.eotv = 0; e.xfer = 0; e.cw = 0; e.tag = "R5";
            end
            cur_busy = e.xfer;
            chk(bus_rd == e.rd, e.tag, "bus_rd", 16'(bus_rd), 16'(e.rd));
            chk(bus_wr == e.wr, e.tag, "bus_wr", 16'(bus_wr), 16'(e.wr));
            chk(dack_n == e.ackn, e.tag, "dack_n", 16'(dack_n), 16'(e.ackn));
            chk(xfer_end == e.eotv, e.tag, "xfer_end(R6)", 16'(xfer_end), 16'(e.eotv));
            if (e.xfer) chk(bus_addr == e.addr, e.tag, "bus_addr", bus_addr, e.addr);
            if (e.cw) chk(bus_wdata == e.wd, e.tag, "bus_wdata", bus_wdata, e.wd);
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: idle bus during reset
        chk(!bus_rd && !bus_wr, "R11", "strobes", {14'd0, bus_rd, bus_wr}, 16'd0);
        chk(dack_n == 1'b1, "R11", "dack_n", 16'(dack_n), 16'd1);
        chk(xfer_end == 1'b0, "R11", "xfer_end", 16'(xfer_end), 16'd0);
        #1 rst_n = 1'b1;
        mon_on = 1'b1;

        // R10: armed with count zero stays idle; R11: pointers start at zero
        wreg(2'd3, 16'h0001, "R10");
        repeat (4) @(negedge clk);
        wreg(2'd2, 16'd2, "R11");
        drain();

        // R1, R8, R6: incrementing two-cycle run with end pulse
        wreg(2'd0, 16'h0100, "R1");
        wreg(2'd1, 16'h0200, "R1");
        wreg(2'd2, 16'd3, "R1");
        wreg(2'd3, 16'h0039, "R1/R8");
        drain();

        // R10: writes during a run are dropped; R8 fixed destination
        wreg(2'd0, 16'h0300, "R10");
        wreg(2'd1, 16'h0400, "R10");
        wreg(2'd2, 16'd4, "R10");
        wreg(2'd3, 16'h0011, "R8");
        wreg(2'd0, 16'hFFFF, "R10");
        wreg(2'd2, 16'd9, "R10");
        drain();

        // R2, R9, R6, R7: one-cycle memory to peripheral, three requests
        wreg(2'd0, 16'h0500, "R2");
        wreg(2'd1, 16'h0600, "R2");
        wreg(2'd2, 16'd3, "R2");
        wreg(2'd3, 16'h003B, "R2");
        repeat (3) begin
            pulse_req("R2/R9");
            repeat (2) @(negedge clk);
        end
        pulse_req("R7");
        pulse_req("R7");
        drain();
        // R4: destination must still be 0x0600
        wreg(2'd2, 16'd1, "R4");
        wreg(2'd3, 16'h0001, "R4");
        drain();

        // R3: one-cycle peripheral to memory, back-to-back requests, no end pulse
        wreg(2'd0, 16'h0700, "R3");
        wreg(2'd1, 16'h0800, "R3");
        wreg(2'd2, 16'd2, "R3");
        wreg(2'd3, 16'h0037, "R3");
        pulse_req("R3/R9");
        pulse_req("R3/R9");
        pulse_req("R7");
        drain();
        // R4: source must still be 0x0700
        wreg(2'd2, 16'd1, "R4");
        wreg(2'd3, 16'h0001, "R4");
        drain();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule